// File: doc/BRIEF.md
# Pixel Command Unit with One-Word Read Cache

This block carries out single-pixel commands against a video memory that is organised as 16-bit words. A command names a word address, a colour depth, the index of a pixel inside that word and an 8-bit colour. A copy command pulls the addressed pixel out of the word. A write command puts the low bits of the colour into that pixel's field and writes the edited word back. Only the one field changes.

The unit keeps the most recently fetched or written word in a one-word cache. On a hit it finishes the command in the cycle the command is accepted. On a miss it requests the word, holds the command's parameters, and stalls until the read data returns. Copy results are also latched in a register so that later paste-style consumers can use them. Two counters record how many pixels were found non-zero: one for copied pixels and one for overwritten pixels.

Top module: `pixel_cmd_unit`

## Requirements
- R1: A command is accepted (`cmd_accept` high) only in a cycle where `cmd_valid` is high and no read is outstanding. `cmd_accept` stays low during every cycle of a pending read, including the cycle in which `rd_valid` returns. A `rd_valid` pulse while no read is outstanding is ignored.
- R2: A copy (code 4'h1) or write (code 4'h2) whose word address is not cached raises `rd_req` with `rd_addr` = `cmd_addr` in its accept cycle. Its result is produced in the cycle `rd_valid` is high, using the parameters stored at acceptance and not the current command inputs.
- R3: A copy to the cached word address raises `copy_valid` with `copy_colour` in its accept cycle and issues no read.
- R4: One clock after `copy_valid`, `copy_reg` holds the copied pixel, `copy_zero` is 1 exactly when that pixel is zero, and `copy_opt` holds that command's colour. In all other cycles these registers hold their values, and write commands do not change them.
- R5: Depth codes 0, 1, 2, 3 and 4 select 1, 2, 4, 8 and 16 bits per pixel; codes 5 to 7 act as 16. The pixel index is the target's low (4 − depth) bits, or 0 at 16 bits. Index 0 is the most significant field. `copy_colour` is the field, zero-extended.
- R6: A write replaces the selected field with the colour's low bits (at 16 bits, the colour zero-extended) and leaves all other bits unchanged. It raises `wr_req` for one cycle with `wr_addr` and `wr_data`: in the accept cycle on a hit, or in the `rd_valid` cycle on a miss.
- R7: A completed read, or a write, makes its word the cached word. A later copy from that address returns the written pixel without issuing a read.
- R8: `rd_coll_cnt` increases by one for each copy that returns a non-zero pixel. `wr_coll_cnt` increases by one for each write whose replaced pixel was non-zero. Both counters wrap.
- R9: Any other command code is accepted in the cycle it is presented. It produces no `rd_req`, `wr_req` or `copy_valid`, and leaves the cache unchanged.
- R10: Reset invalidates the cache, returns the unit to idle, clears both counters and `copy_reg`/`copy_opt`, and sets `copy_zero`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_code | input | 4 | Command code (1 copy, 2 write) |
| cmd_addr | input | AW | Word address |
| cmd_depth | input | 3 | Depth code (log2 of bits per pixel) |
| cmd_target | input | 4 | Pixel index inside the word |
| cmd_colour | input | 8 | Command colour |
| cmd_accept | output | 1 | Command consumed this cycle |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | AW | Read word address |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 16 | Read data word |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | AW | Write word address |
| wr_data | output | 16 | Edited word |
| copy_valid | output | 1 | Copy result present this cycle |
| copy_colour | output | 16 | Copied pixel |
| copy_reg | output | 16 | Registered copied pixel |
| copy_zero | output | 1 | Registered pixel is zero |
| copy_opt | output | 8 | Registered copy command colour |
| rd_coll_cnt | output | CNT_W | Non-zero copied pixel count |
| wr_coll_cnt | output | CNT_W | Non-zero overwritten pixel count |

## Verification
The main same-cycle case is the return of read data while a new command is already waiting with different depth, target and colour. The bench provokes it by presenting the next command right after a miss is accepted, with the memory latency set to several cycles. Two things are judged. The returned pixel must match the parameters stored with the missed command. The waiting command must be accepted exactly one cycle after the data cycle, and as a cache hit. The bench also aims a write at the cached word. It then judges the edited word on `wr_data`, the later copy served from the cache without a read, and the write-collision count in that same cycle.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int WORD_W  = 16;
  localparam int COL_W   = 8;
  localparam int CODE_W  = 4;
  localparam int DEPTH_W = 3;
  localparam int TGT_W   = 4;

  localparam logic [CODE_W-1:0] OP_COPY  = 4'h1;
  localparam logic [CODE_W-1:0] OP_WRITE = 4'h2;

  typedef struct packed {
    logic [DEPTH_W-1:0] depth;
    logic [TGT_W-1:0]   target;
    logic [COL_W-1:0]   colour;
  } pix_sel_t;
endpackage

// File: rtl/pcu_pixel_lane.sv
// Field extraction and merge for one word; index 0 sits at the MSB end.
module pcu_pixel_lane
  import pcu_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  pix_sel_t          sel_i,
  output logic [WORD_W-1:0] pixel_o,
  output logic [WORD_W-1:0] merged_o,
  output logic              nonzero_o
);
  logic [4:0]        bpp;
  logic [TGT_W-1:0]  idx_mask;
  logic [TGT_W-1:0]  idx;
  logic [8:0]        span;
  logic [4:0]        shift;
  logic [WORD_W-1:0] lo_mask;
  logic [WORD_W-1:0] field_mask;
  logic [WORD_W-1:0] wval;

  always_comb begin
    case (sel_i.depth)
      3'd0:    begin bpp = 5'd1; idx_mask = 4'hF; lo_mask = 16'h0001; end
      3'd1:    begin bpp = 5'd2; idx_mask = 4'h7; lo_mask = 16'h0003; end
      3'd2:    begin bpp = 5'd4; idx_mask = 4'h3; lo_mask = 16'h000F; end
      3'd3:    begin bpp = 5'd8; idx_mask = 4'h1; lo_mask = 16'h00FF; end
      default: begin bpp = 5'd16; idx_mask = 4'h0; lo_mask = 16'hFFFF; end
    endcase
    idx        = sel_i.target & idx_mask;
    span       = 9'(bpp) * (9'(idx) + 9'd1);
    shift      = 5'(9'd16 - span);
    field_mask = lo_mask << shift;
    pixel_o    = (word_i >> shift) & lo_mask;
    wval       = {{(WORD_W-COL_W){1'b0}}, sel_i.colour} & lo_mask;
    merged_o   = (word_i & ~field_mask) | (wval << shift);
    nonzero_o  = |pixel_o;
  end
endmodule

// File: rtl/pcu_word_cache.sv
module pcu_word_cache
  import pcu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_i,
  input  logic [AW-1:0]     fill_addr_i,
  input  logic [WORD_W-1:0] fill_word_i,
  input  logic [AW-1:0]     look_addr_i,
  output logic              hit_o,
  output logic [WORD_W-1:0] word_o
);
  logic              valid_q, valid_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [WORD_W-1:0] word_q, word_d;

  always_comb begin
    valid_d = 1'b1;
    addr_d  = fill_addr_i;
    word_d  = fill_word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      word_q  <= '0;
    end else if (fill_i) begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      word_q  <= word_d;
    end
  end

  assign hit_o  = valid_q && (addr_q == look_addr_i);
  assign word_o = word_q;

  p_fill_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_i |=> (word_o == $past(fill_word_i)));
endmodule

// File: rtl/pcu_event_ctr.sv
module pcu_event_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] count_q, count_d;

  always_comb count_d = count_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (inc_i) count_q <= count_d;
  end

  assign count_o = count_q;

  p_count_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(count_o));
endmodule

// File: rtl/pixel_cmd_unit.sv
module pixel_cmd_unit
  import pcu_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [CODE_W-1:0]  cmd_code,
  input  logic [AW-1:0]      cmd_addr,
  input  logic [DEPTH_W-1:0] cmd_depth,
  input  logic [TGT_W-1:0]   cmd_target,
  input  logic [COL_W-1:0]   cmd_colour,
  output logic               cmd_accept,
  output logic               rd_req,
  output logic [AW-1:0]      rd_addr,
  input  logic               rd_valid,
  input  logic [WORD_W-1:0]  rd_data,
  output logic               wr_req,
  output logic [AW-1:0]      wr_addr,
  output logic [WORD_W-1:0]  wr_data,
  output logic               copy_valid,
  output logic [WORD_W-1:0]  copy_colour,
  output logic [WORD_W-1:0]  copy_reg,
  output logic               copy_zero,
  output logic [COL_W-1:0]   copy_opt,
  output logic [CNT_W-1:0]   rd_coll_cnt,
  output logic [CNT_W-1:0]   wr_coll_cnt
);
  localparam int N_CTR = 2;

  // pending-miss state
  logic          busy_q, busy_d;
  logic          pend_wr_q;
  logic [AW-1:0] pend_addr_q;
  pix_sel_t      pend_sel_q;

  // registered copy result
  logic [WORD_W-1:0] creg_q, creg_d;
  logic              czero_q, czero_d;
  logic [COL_W-1:0]  copt_q, copt_d;

  pix_sel_t          cmd_sel, lane_sel;
  logic              exec, is_copy, is_write, is_mem, hit, arrive, resolve, op_write;
  logic [AW-1:0]     op_addr;
  logic [WORD_W-1:0] cache_word, lane_word, pixel, merged, fill_word;
  logic              old_nz, fill;
  logic [N_CTR-1:0]  coll_inc;
  logic [CNT_W-1:0]  coll_cnt [N_CTR];

  always_comb begin
    cmd_sel  = '{depth: cmd_depth, target: cmd_target, colour: cmd_colour};
    exec     = cmd_valid & ~busy_q;
    is_copy  = (cmd_code == OP_COPY);
    is_write = (cmd_code == OP_WRITE);
    is_mem   = is_copy | is_write;
    arrive   = busy_q & rd_valid;
    // while a miss is pending, the stored command drives the datapath
    lane_word = busy_q ? rd_data     : cache_word;
    lane_sel  = busy_q ? pend_sel_q  : cmd_sel;
    op_write  = busy_q ? pend_wr_q   : is_write;
    op_addr   = busy_q ? pend_addr_q : cmd_addr;
    resolve   = arrive | (exec & is_mem & hit);

    cmd_accept  = exec;
    rd_req      = exec & is_mem & ~hit;
    rd_addr     = cmd_addr;
    wr_req      = resolve & op_write;
    wr_addr     = op_addr;
    wr_data     = merged;
    copy_valid  = resolve & ~op_write;
    copy_colour = pixel;

    fill      = arrive | wr_req;
    fill_word = op_write ? merged : rd_data;

    busy_d  = busy_q ? ~rd_valid : rd_req;
    creg_d  = pixel;
    czero_d = ~old_nz;
    copt_d  = lane_sel.colour;

    coll_inc = {wr_req & old_nz, copy_valid & old_nz};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_wr_q   <= 1'b0;
      pend_addr_q <= '0;
      pend_sel_q  <= '0;
    end else if (rd_req) begin
      pend_wr_q   <= is_write;
      pend_addr_q <= cmd_addr;
      pend_sel_q  <= cmd_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      creg_q  <= '0;
      czero_q <= 1'b1;
      copt_q  <= '0;
    end else if (copy_valid) begin
      creg_q  <= creg_d;
      czero_q <= czero_d;
      copt_q  <= copt_d;
    end
  end

  assign copy_reg  = creg_q;
  assign copy_zero = czero_q;
  assign copy_opt  = copt_q;

  pcu_word_cache #(.AW(AW)) u_cache (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_i      (fill),
    .fill_addr_i (op_addr),
    .fill_word_i (fill_word),
    .look_addr_i (cmd_addr),
    .hit_o       (hit),
    .word_o      (cache_word)
  );

  pcu_pixel_lane u_lane (
    .word_i    (lane_word),
    .sel_i     (lane_sel),
    .pixel_o   (pixel),
    .merged_o  (merged),
    .nonzero_o (old_nz)
  );

  for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
    pcu_event_ctr #(.W(CNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (coll_inc[i]),
      .count_o (coll_cnt[i])
    );
  end

  assign rd_coll_cnt = coll_cnt[0];
  assign wr_coll_cnt = coll_cnt[1];

  p_no_accept_after_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !cmd_accept);
  p_miss_defers_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (!copy_valid && !wr_req));
  p_single_action_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, wr_req, copy_valid}));
  p_copy_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    copy_valid |=> (copy_reg == $past(copy_colour)) && (copy_zero == ($past(copy_colour) == '0)));
  p_copy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_valid |=> ($stable(copy_reg) && $stable(copy_opt) && $stable(copy_zero)));
endmodule

// File: tb/pixel_cmd_unit_tb.sv
module pixel_cmd_unit_tb;
  localparam int AW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cmd_valid, cmd_accept, rd_req, rd_valid, wr_req, copy_valid, copy_zero;
  logic [3:0]  cmd_code, cmd_target;
  logic [2:0]  cmd_depth;
  logic [7:0]  cmd_colour, copy_opt;
  logic [AW-1:0] cmd_addr, rd_addr, wr_addr;
  logic [15:0] rd_data, wr_data, copy_colour, copy_reg;
  logic [CW-1:0] rd_coll_cnt, wr_coll_cnt;

  pixel_cmd_unit #(.AW(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .cmd_depth(cmd_depth), .cmd_target(cmd_target),
    .cmd_colour(cmd_colour), .cmd_accept(cmd_accept), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(wr_data), .copy_valid(copy_valid),
    .copy_colour(copy_colour), .copy_reg(copy_reg), .copy_zero(copy_zero),
    .copy_opt(copy_opt), .rd_coll_cnt(rd_coll_cnt), .wr_coll_cnt(wr_coll_cnt)
  );

  typedef struct {
    bit          is_wr;
    logic [15:0] addr;
    logic [15:0] val;
    logic [7:0]  col;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0, fails = 0, cyc = 0, rd_count = 0, lat = 2;
  int          exp_rdc = 0, exp_wrc = 0, wait_cyc = 0;
  bit          done = 0, acc_act = 0, reg_chk = 0;
  logic [15:0] reg_val, last_copy;
  logic [7:0]  reg_col;
  logic [15:0] ram [256];
  logic [15:0] ref_mem [256];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic int bpp_of(input logic [2:0] d);
    return (d < 3'd4) ? (1 << d) : 16;
  endfunction

  function automatic logic [15:0] mask_of(input logic [2:0] d);
    return 16'((32'd1 << bpp_of(d)) - 32'd1);
  endfunction

  function automatic int shift_of(input logic [2:0] d, input logic [3:0] t);
    int b = bpp_of(d);
    int idx = int'(t) % (16 / b);
    return 16 - b * (idx + 1);
  endfunction

  // driver: computes expected result from the reference memory, then presents the command
  task automatic do_cmd(input logic [3:0] code, input logic [15:0] a, input logic [2:0] d,
                        input logic [3:0] t, input logic [7:0] c, input string tag);
    exp_t        e;
    int          sh, drv;
    logic [15:0] m, old, pix, nw;
    sh  = shift_of(d, t);
    m   = mask_of(d);
    old = ref_mem[a[7:0]];
    pix = (old >> sh) & m;
    if (code == 4'h1) begin
      e = '{1'b0, a, pix, c, tag};
      sb.push_back(e);
      if (pix != 0) exp_rdc++;
    end else if (code == 4'h2) begin
      nw = (old & ~(m << sh)) | (({8'h00, c} & m) << sh);
      e = '{1'b1, a, nw, c, tag};
      sb.push_back(e);
      ref_mem[a[7:0]] = nw;
      if (pix != 0) exp_wrc++;
    end
    cmd_code = code; cmd_addr = a; cmd_depth = d; cmd_target = t; cmd_colour = c;
    cmd_valid = 1'b1;
    drv = cyc;
    do @(negedge clk); while (!cmd_accept);
    wait_cyc = cyc - drv;
    acc_act  = copy_valid | wr_req;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(posedge clk);
    idle(2);
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin : monitor
    exp_t e;
    if (rst_n && !done) begin
      if (reg_chk) begin
        chk("R4 copy_reg", {24'h0, copy_reg}, {24'h0, reg_val});
        chk("R4 copy_zero", {39'h0, copy_zero}, {39'h0, (reg_val == 16'h0)});
        chk("R4 copy_opt", {32'h0, copy_opt}, {32'h0, reg_col});
        reg_chk = 0;
      end
      if (rd_req) rd_count++;
      if (copy_valid || wr_req) begin
        if (sb.size() == 0) begin
          checks++; fails++;
          $display("FAIL R9 unexpected result actual=%0h expected=none",
                   copy_valid ? copy_colour : wr_data);
        end else begin
          e = sb.pop_front();
          if (copy_valid) begin
            chk({e.tag, " copy result"}, {23'h0, e.is_wr, copy_colour}, {23'h0, 1'b0, e.val});
            reg_chk = 1; reg_val = e.val; reg_col = e.col; last_copy = e.val;
          end else begin
            chk({e.tag, " write result"}, {7'h0, e.is_wr, wr_addr, wr_data}, {7'h0, 1'b1, e.addr, e.val});
          end
        end
      end
    end
  end

  // memory model: one outstanding read, latency lat cycles
  initial begin : responder
    logic [7:0] a;
    rd_valid = 1'b0;
    rd_data  = '0;
    forever begin
      @(posedge clk);
      if (rd_req && rst_n) begin
        a = rd_addr[7:0];
        repeat (lat - 1) @(posedge clk);
        #1; rd_valid = 1'b1; rd_data = ram[a];
        @(posedge clk);
        #1; rd_valid = 1'b0; rd_data = '0;
      end
    end
  end

  always @(posedge clk) if (rst_n && wr_req) ram[wr_addr[7:0]] <= wr_data;

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_up();
    end
  end

  initial begin : main
    int r0;
    for (int i = 0; i < 256; i++) begin
      ram[i] = 16'(i * 40503) ^ 16'h5A3C;
      ref_mem[i] = ram[i];
    end
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = '0; cmd_addr = '0;
    cmd_depth = '0; cmd_target = '0; cmd_colour = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset rd_req", {39'h0, rd_req}, 40'h0);
    chk("R10 reset wr_req/copy_valid", {38'h0, wr_req, copy_valid}, 40'h0);
    chk("R10 reset copy_reg", {24'h0, copy_reg}, 40'h0);
    chk("R10 reset copy_zero/opt", {31'h0, copy_zero, copy_opt}, {31'h0, 1'b1, 8'h0});
    chk("R10 reset counters", {8'h0, rd_coll_cnt, wr_coll_cnt}, 40'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    idle(1);

    r0 = rd_count;
    do_cmd(4'h1, 16'd5, 3'd3, 4'd0, 8'h01, "R2");
    chk("R2 miss read issued", 40'(rd_count - r0), 40'd1);
    chk("R2 no result in accept cycle", {39'h0, acc_act}, 40'h0);

    r0 = rd_count;
    do_cmd(4'h1, 16'd5, 3'd3, 4'd1, 8'h07, "R3");
    chk("R3 hit result same cycle", {39'h0, acc_act}, 40'h1);
    do_cmd(4'h1, 16'd5, 3'd0, 4'd0, 8'h02, "R5");
    do_cmd(4'h1, 16'd5, 3'd0, 4'd15, 8'h03, "R5");
    do_cmd(4'h1, 16'd5, 3'd1, 4'd3, 8'h04, "R5");
    do_cmd(4'h1, 16'd5, 3'd2, 4'd2, 8'h05, "R5");
    do_cmd(4'h1, 16'd5, 3'd4, 4'd9, 8'h06, "R5");
    do_cmd(4'h1, 16'd5, 3'd7, 4'd0, 8'h07, "R5");
    do_cmd(4'h1, 16'd5, 3'd3, 4'd5, 8'h08, "R5");
    chk("R3 hits issued no read", 40'(rd_count - r0), 40'd0);

    drain();
    r0 = rd_count;
    do_cmd(4'h2, 16'd5, 3'd2, 4'd1, 8'h0B, "R6");
    chk("R6 hit write same cycle", {39'h0, acc_act}, 40'h1);
    drain();
    chk("R4 copy_reg unchanged by write", {24'h0, copy_reg}, {24'h0, last_copy});
    do_cmd(4'h1, 16'd5, 3'd2, 4'd1, 8'h01, "R7");
    chk("R7 copy after write no read", 40'(rd_count - r0), 40'd0);

    r0 = rd_count;
    do_cmd(4'h2, 16'd9, 3'd0, 4'd3, 8'h01, "R6");
    do_cmd(4'h1, 16'd9, 3'd0, 4'd3, 8'h09, "R7");
    do_cmd(4'h2, 16'd9, 3'd4, 4'd0, 8'h9C, "R6");
    do_cmd(4'h1, 16'd9, 3'd3, 4'd1, 8'h0A, "R7");
    chk("R6 write miss one read only", 40'(rd_count - r0), 40'd1);
    drain();

    lat = 4;
    do_cmd(4'h1, 16'd20, 3'd3, 4'd0, 8'h03, "R1");
    do_cmd(4'h1, 16'd20, 3'd1, 4'd6, 8'h02, "R1");
    chk("R1 held through data cycle", 40'(wait_cyc), 40'(lat));
    chk("R1 held command served as hit", {39'h0, acc_act}, 40'h1);
    drain();
    lat = 2;

    r0 = rd_count;
    do_cmd(4'hF, 16'd20, 3'd3, 4'd0, 8'h11, "R9");
    chk("R9 unknown code accepted at once", 40'(wait_cyc), 40'd0);
    do_cmd(4'h0, 16'd77, 3'd3, 4'd0, 8'h12, "R9");
    idle(3);
    chk("R9 unknown code no read", 40'(rd_count - r0), 40'd0);
    chk("R9 copy_reg untouched", {24'h0, copy_reg}, {24'h0, last_copy});
    do_cmd(4'h1, 16'd20, 3'd3, 4'd1, 8'h04, "R9");
    chk("R9 cache intact after unknown code", 40'(rd_count - r0), 40'd0);
    drain();

    @(posedge clk); #1 rd_valid = 1'b1; rd_data = 16'hFFFF;
    @(posedge clk); #1 rd_valid = 1'b0; rd_data = '0;
    idle(2);
    chk("R1 stray data ignored copy_reg", {24'h0, copy_reg}, {24'h0, last_copy});
    chk("R1 stray data ignored counter", 40'(rd_coll_cnt), 40'(exp_rdc));

    do_cmd(4'h2, 16'd20, 3'd3, 4'd0, 8'h00, "R6");
    do_cmd(4'h1, 16'd20, 3'd3, 4'd0, 8'h05, "R4");
    do_cmd(4'h2, 16'd30, 3'd2, 4'd3, 8'h0E, "R6");
    do_cmd(4'h2, 16'd30, 3'd2, 4'd3, 8'h03, "R6");
    do_cmd(4'h1, 16'd30, 3'd2, 4'd3, 8'h06, "R7");
    drain();
    chk("R8 read collision count", 40'(rd_coll_cnt), 40'(exp_rdc));
    chk("R8 write collision count", 40'(wr_coll_cnt), 40'(exp_wrc));

    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 mid-run counters cleared", {8'h0, rd_coll_cnt, wr_coll_cnt}, 40'h0);
    chk("R10 mid-run copy_reg cleared", {24'h0, copy_reg}, 40'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    exp_rdc = 0; exp_wrc = 0;
    r0 = rd_count;
    do_cmd(4'h1, 16'd30, 3'd2, 4'd3, 8'h07, "R10");
    chk("R10 cache invalid after reset", 40'(rd_count - r0), 40'd1);
    drain();
    chk("R8 count after reset", 40'(rd_coll_cnt), 40'(exp_rdc));
    finish_up();
  end
endmodule